// File: doc/BRIEF.md
# Passive-Infrared Comparator Post-Processor

This block sits behind the analogue front end of one passive-infrared channel. That front end has two threshold comparators, one for positive swings and one for negative swings. The block takes their raw levels, synchronises them to the system clock and turns every low-to-high transition into a one-cycle event. It then applies one of three false-trigger rejection policies, chosen at run time, and reports an intrusion as a single-cycle alarm pulse.

The first policy alarms on any event. The second stretches each polarity's event into a hold window of programmable length and alarms only when both holds overlap. The third counts events of either polarity and alarms once a programmable number of them land inside a programmable window. All three policies share the same edge-detection front end. After an alarm, a reset or any change of the mode select, every timer and counter in the block clears.

Top module: `pir_postproc`

## Requirements
- R1: Each comparator input passes through a two-flop synchroniser. A low-to-high change of the synchronised level is one event, and a level that stays high produces no further events. In single-shot mode the alarm is high in the third clock cycle after the first clock edge that samples the input high.
- R2: The mode select encoding is 0 for single-shot, 1 for dual-polarity, 2 for pulse-count and 3 for disabled. In disabled mode no input activity ever raises the alarm.
- R3: In single-shot mode, an event on either polarity raises a one-cycle alarm. The alarm can only follow an event.
- R4: In dual-polarity mode, each event holds its polarity active for `stretch_len` cycles, counted from the cycle after the event. The alarm is raised when both polarities are held at once. An opposite-polarity input rising up to `stretch_len`-1 cycles after the first rising input alarms, four cycles after its own rise. A rise `stretch_len` cycles later does not alarm.
- R5: In dual-polarity mode, a new event on a polarity that is already held restarts that polarity's hold at the full `stretch_len`.
- R6: In dual-polarity mode, events on only one polarity never raise the alarm.
- R7: In pulse-count mode, the window opens on the first counted event and lasts `window_len` cycles after it. The alarm fires in the cycle after the event that brings the count to `pulse_need`. An event arriving exactly `window_len` cycles after the opening event still counts.
- R8: In pulse-count mode, events from both polarities count. Events on both polarities in the same cycle count as two.
- R9: In pulse-count mode, if the window runs out before `pulse_need` events arrive, the count and the window clear. An event that arrives after expiry opens a fresh window with a count of one.
- R10: After an alarm, all holds, the count and the window are cleared, so later events start from empty state.
- R11: Any change of the mode select clears all holds, the count and the window, and no alarm is raised for that cycle.
- R12: During reset the alarm is low. Reset clears all synchronisers, holds, the count and the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_pos | input | 1 | Asynchronous positive-threshold comparator level |
| cmp_neg | input | 1 | Asynchronous negative-threshold comparator level |
| mode_sel | input | 2 | Policy select: 0 single-shot, 1 dual-polarity, 2 pulse-count, 3 disabled |
| stretch_len | input | STRETCH_W | Hold length in cycles for dual-polarity mode |
| pulse_need | input | CNT_W | Number of events that raise the alarm in pulse-count mode |
| window_len | input | WIN_W | Pulse-count window length in cycles |
| alarm | output | 1 | One-cycle alarm pulse |

## Verification
The bench builds the block with an 8-bit hold timer, a 4-bit pulse counter and an 8-bit window timer. It runs with a hold of 10 cycles, a window of 20 cycles and a required count of 3. These values put the hold-overlap edge (a gap of 9 alarms, a gap of 10 does not) and the window edge (offset 20 counts, offset 21 expires) within a few dozen cycles. Restart, clear-after-alarm and mode-change scenarios are each arranged so that a design missing the clear or the restart would raise an alarm where none is expected.

// File: rtl/pir_pp_pkg.sv
package pir_pp_pkg;

  typedef enum logic [1:0] {
    PP_SINGLE = 2'd0,
    PP_DUAL   = 2'd1,
    PP_COUNT  = 2'd2,
    PP_OFF    = 2'd3
  } pp_mode_e;

  // Number of events present in one cycle (0, 1 or 2).
  function automatic logic [1:0] rise_weight(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/pir_edge_front.sv
module pir_edge_front #(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] rise
);

  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        last_q  <= chain_q[TOP];
      end
    end

    assign rise[g] = chain_q[TOP] & ~last_q;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]); // R1
  end

endmodule

// File: rtl/pir_stretch.sv
module pir_stretch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         trig,
  input  logic [W-1:0] len,
  output logic         held
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !en)       remain_q <= '0;
    else if (trig)               remain_q <= len;
    else if (remain_q != '0)     remain_q <= remain_q - W'(1);
  end

  assign held = (remain_q != '0);

  AST_STRETCH_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && trig) |=> (remain_q == $past(len))); // R5

  AST_STRETCH_DROP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !trig && remain_q == W'(1)) |=> !held); // R4

endmodule

// File: rtl/pir_pulse_window.sv
module pir_pulse_window #(
  parameter int CW = 8,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [1:0]    inc,
  input  logic [CW-1:0] need,
  input  logic [WW-1:0] win_len,
  output logic          hit,
  output logic          open
);

  localparam int TW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [WW-1:0] win_q;
  logic          live;
  logic [TW-1:0] total;

  // Count after this cycle's events; a dead window contributes nothing.
  function automatic logic [TW-1:0] running_total(input logic alive,
                                                  input logic [CW-1:0] cur,
                                                  input logic [1:0] add);
    logic [TW-1:0] base;
    base = alive ? {1'b0, cur} : '0;
    return base + TW'(add);
  endfunction

  assign live  = (cnt_q != '0) && (win_q != '0);
  assign total = running_total(live, cnt_q, inc);
  assign hit   = en && (inc != 2'd0) && (total >= {1'b0, need});
  assign open  = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (live) begin
      cnt_q <= total[CW-1:0];
      win_q <= win_q - WW'(1);
    end else if (inc != 2'd0) begin
      cnt_q <= CW'(inc);
      win_q <= win_len;
    end else begin
      cnt_q <= '0;
      win_q <= '0;
    end
  end

  AST_WIN_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && cnt_q != '0 && win_q == '0 && inc == 2'd0) |=> (cnt_q == '0)); // R9

  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && cnt_q == '0 && inc != 2'd0) |=> (win_q == $past(win_len))); // R7

endmodule

// File: rtl/pir_postproc.sv
module pir_postproc
  import pir_pp_pkg::*;
#(
  parameter int STRETCH_W = 16,
  parameter int CNT_W     = 8,
  parameter int WIN_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmp_pos,
  input  logic                 cmp_neg,
  input  logic [1:0]           mode_sel,
  input  logic [STRETCH_W-1:0] stretch_len,
  input  logic [CNT_W-1:0]     pulse_need,
  input  logic [WIN_W-1:0]     window_len,
  output logic                 alarm
);

  localparam int LANES = 2;

  pp_mode_e   mode_in, mode_q;
  logic       mode_chg;
  logic [1:0] rise;
  logic       ev_pos, ev_neg;
  logic       held_pos, held_neg;
  logic       pc_hit, pc_open;
  logic       alarm_d, alarm_q;
  logic       clr_all;
  logic       dual_en, count_en;

  assign mode_in  = pp_mode_e'(mode_sel);
  assign mode_chg = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    mode_q <= mode_in;
  end

  pir_edge_front #(.LANES(LANES), .SYNC_STAGES(2)) u_front (
    .clk  (clk),
    .rst  (rst),
    .raw  ({cmp_neg, cmp_pos}),
    .rise (rise)
  );

  assign ev_pos   = rise[0];
  assign ev_neg   = rise[1];
  assign dual_en  = (mode_q == PP_DUAL);
  assign count_en = (mode_q == PP_COUNT);
  assign clr_all  = mode_chg | alarm_d;

  pir_stretch #(.W(STRETCH_W)) u_hold_pos (
    .clk (clk), .rst (rst), .clr (clr_all), .en (dual_en),
    .trig (ev_pos), .len (stretch_len), .held (held_pos)
  );

  pir_stretch #(.W(STRETCH_W)) u_hold_neg (
    .clk (clk), .rst (rst), .clr (clr_all), .en (dual_en),
    .trig (ev_neg), .len (stretch_len), .held (held_neg)
  );

  pir_pulse_window #(.CW(CNT_W), .WW(WIN_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_all),
    .en      (count_en),
    .inc     (rise_weight(ev_pos, ev_neg)),
    .need    (pulse_need),
    .win_len (window_len),
    .hit     (pc_hit),
    .open    (pc_open)
  );

  always_comb begin
    case (mode_q)
      PP_SINGLE: alarm_d = ev_pos | ev_neg;
      PP_DUAL:   alarm_d = held_pos & held_neg;
      PP_COUNT:  alarm_d = pc_hit;
      default:   alarm_d = 1'b0;
    endcase
    if (mode_chg) alarm_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_q <= 1'b0;
    else     alarm_q <= alarm_d;
  end

  assign alarm = alarm_q;

  AST_CLEAR_AFTER_ALARM: assert property (@(posedge clk) disable iff (rst)
    alarm_q |-> (!held_pos && !held_neg && !pc_open)); // R10

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(mode_chg) |-> (!alarm_q && !held_pos && !held_neg && !pc_open)); // R11

  AST_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && $past(mode_q) == PP_SINGLE) |-> $past(ev_pos || ev_neg)); // R3

  AST_DUAL_BOTH: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && $past(mode_q) == PP_DUAL) |-> $past(held_pos && held_neg)); // R4

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == PP_OFF) |-> !alarm_q); // R2

endmodule

// File: tb/pir_postproc_tb.sv
module pir_postproc_tb;

  localparam int SW = 8;
  localparam int CW = 4;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmp_pos, cmp_neg;
  logic [1:0]    mode_sel;
  logic [SW-1:0] stretch_len;
  logic [CW-1:0] pulse_need;
  logic [WW-1:0] window_len;
  logic          alarm;

  always #5 clk = ~clk;

  pir_postproc #(.STRETCH_W(SW), .CNT_W(CW), .WIN_W(WW)) u_dut (
    .clk (clk), .rst (rst), .cmp_pos (cmp_pos), .cmp_neg (cmp_neg),
    .mode_sel (mode_sel), .stretch_len (stretch_len), .pulse_need (pulse_need),
    .window_len (window_len), .alarm (alarm)
  );

  typedef struct { int at; string req; } exp_t;
  exp_t  sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    stray = 0;
  string cur_req = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare alarm against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0 && sb[0].at < cyc) begin
        checks++; errors++;
        $display("FAIL %s: cycle %0d alarm actual 0 expected 1", sb[0].req, sb[0].at);
        void'(sb.pop_front());
      end
      if (alarm) begin
        if (sb.size() > 0 && sb[0].at == cyc) begin
          checks++;
          void'(sb.pop_front());
        end else begin
          checks++; errors++; stray++;
          $display("FAIL %s: cycle %0d alarm actual 1 expected 0", cur_req, cyc);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int at, input string req);
    exp_t e;
    e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  task automatic pulse(input logic p, input logic n);
    if (p) cmp_pos = 1'b1;
    if (n) cmp_neg = 1'b1;
    tick(2);
    cmp_pos = 1'b0;
    cmp_neg = 1'b0;
  endtask

  task automatic quiet_check(input string req, input int s0);
    checks++;
    if (stray != s0) begin
      errors++;
      $display("FAIL %s: stray alarms actual %0d expected 0", req, stray - s0);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung actual running expected done");
    finish_run();
  end

  initial begin
    int s0;
    rst = 1'b1; cmp_pos = 1'b0; cmp_neg = 1'b0; mode_sel = 2'd0;
    stretch_len = SW'(10); pulse_need = CW'(3); window_len = WW'(20);
    tick(4);
    checks++;
    if (alarm !== 1'b0) begin
      errors++; $display("FAIL R12: alarm in reset actual %b expected 0", alarm);
    end
    rst = 1'b0;
    tick(4);

    // R1 / R3: single-shot, held level alarms once
    cur_req = "R1"; s0 = stray;
    expect_at(cyc + 3, "R1");
    cmp_pos = 1'b1; tick(8); cmp_pos = 1'b0; tick(10);
    quiet_check("R1", s0);
    cur_req = "R3";
    expect_at(cyc + 3, "R3");
    pulse(1'b0, 1'b1); tick(2);
    expect_at(cyc + 3, "R3");
    pulse(1'b1, 1'b0); tick(12);

    // Dual-polarity mode
    mode_sel = 2'd1; tick(5);
    cur_req = "R4";
    pulse(1'b1, 1'b0); tick(7);
    expect_at(cyc + 4, "R4");
    pulse(1'b0, 1'b1); tick(30);
    s0 = stray;
    pulse(1'b1, 1'b0); tick(8);
    pulse(1'b0, 1'b1); tick(30);
    quiet_check("R4", s0);

    cur_req = "R6"; s0 = stray;
    pulse(1'b1, 1'b0); tick(5); pulse(1'b1, 1'b0); tick(30);
    pulse(1'b0, 1'b1); tick(3); pulse(1'b0, 1'b1); tick(30);
    quiet_check("R6", s0);

    cur_req = "R5";
    pulse(1'b1, 1'b0); tick(4);
    pulse(1'b1, 1'b0); tick(7);
    expect_at(cyc + 4, "R5");
    pulse(1'b0, 1'b1); tick(30);

    cur_req = "R10";
    pulse(1'b0, 1'b1);
    expect_at(cyc + 4, "R10");
    pulse(1'b1, 1'b0); tick(4);
    s0 = stray;
    pulse(1'b1, 1'b0); tick(30);
    quiet_check("R10", s0);

    cur_req = "R11"; s0 = stray;
    pulse(1'b1, 1'b0); tick(3);
    mode_sel = 2'd2; tick(1); mode_sel = 2'd1; tick(2);
    pulse(1'b0, 1'b1); tick(30);
    quiet_check("R11", s0);

    cur_req = "R12"; s0 = stray;
    pulse(1'b1, 1'b0);
    rst = 1'b1; tick(1);
    checks++;
    if (alarm !== 1'b0) begin
      errors++; $display("FAIL R12: alarm in reset actual %b expected 0", alarm);
    end
    rst = 1'b0; tick(1);
    pulse(1'b0, 1'b1); tick(30);
    quiet_check("R12", s0);

    // Disabled mode
    mode_sel = 2'd3; tick(5);
    cur_req = "R2"; s0 = stray;
    pulse(1'b1, 1'b0); tick(2); pulse(1'b0, 1'b1); tick(2); pulse(1'b1, 1'b1); tick(20);
    quiet_check("R2", s0);

    // Pulse-count mode
    mode_sel = 2'd2; tick(5);
    cur_req = "R7";
    pulse(1'b1, 1'b0); tick(3);
    pulse(1'b0, 1'b1); tick(3);
    expect_at(cyc + 3, "R7");
    pulse(1'b1, 1'b0); tick(40);
    pulse(1'b1, 1'b0); tick(8);
    pulse(1'b1, 1'b0); tick(8);
    expect_at(cyc + 3, "R7");
    pulse(1'b1, 1'b0); tick(40);

    cur_req = "R9"; s0 = stray;
    pulse(1'b1, 1'b0); tick(8);
    pulse(1'b1, 1'b0); tick(9);
    pulse(1'b1, 1'b0); tick(3);
    quiet_check("R9", s0);
    pulse(1'b0, 1'b1); tick(3);
    expect_at(cyc + 3, "R9");
    pulse(1'b1, 1'b0); tick(40);

    cur_req = "R8";
    pulse(1'b1, 1'b1); tick(3);
    expect_at(cyc + 3, "R8");
    pulse(1'b1, 1'b0); tick(40);

    cur_req = "R10";
    pulse(1'b1, 1'b0); tick(2);
    pulse(1'b1, 1'b0); tick(2);
    expect_at(cyc + 3, "R10");
    pulse(1'b0, 1'b1); tick(2);
    s0 = stray;
    pulse(1'b1, 1'b0); tick(2);
    pulse(1'b1, 1'b0); tick(40);
    quiet_check("R10", s0);

    tick(10);
    while (sb.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: cycle %0d alarm actual 0 expected 1", sb[0].req, sb[0].at);
      void'(sb.pop_front());
    end
    finish_run();
  end

endmodule